// File: doc/BRIEF.md
# Peripheral Soft-Reset Handshake Sequencer

This block runs the full soft-reset handshake for one peripheral whose control word carries a soft-reset bit (bit 31) and a clock-gate bit (bit 30). A single-cycle start pulse launches a fixed five-write program: release soft reset and confirm it, ungate the clock, assert soft reset and wait for the peripheral to gate its own clock as acknowledgement, then release soft reset and ungate the clock again, confirming both. Each write goes out as a one-cycle set or clear strobe with a one-hot bit mask. The read-data word is sampled directly for polling.

Every polled write is followed by a settle window of `SETTLE_CYCLES` clocks before the first read. The block then takes one poll sample per cycle, up to `MAX_POLLS` samples. If the expected value has not appeared by then, the program aborts with a one-cycle error pulse and no further writes are issued. A one-cycle done pulse marks success. The block is used wherever a hardware engine, rather than firmware, must bring a peripheral out of reset in a known state.

Top module: `soft_reset_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the block to idle: `busy_o`, both strobes, `done_o` and `error_o` are low on the following cycle, and no strobe appears afterwards until a new start.
- R2: A successful run issues exactly five writes, one strobe per cycle and never both strobes at once, in this order: clear bit 31, clear bit 30, set bit 31, clear bit 31, clear bit 30; the mask has only the addressed bit set.
- R3: After each polled write, exactly `SETTLE_CYCLES` cycles pass before the first poll sample; the bit-30 clear in the second step is not polled, and the bit-31 set follows it on the very next cycle.
- R4: After setting bit 31, the block waits until the read-back bit 30 is 1 before it issues the following write.
- R5: Each poll loop takes at most `MAX_POLLS` samples, one per cycle; a match on the last allowed sample still counts as success.
- R6: When a poll loop's samples run out without a match, `error_o` pulses for one cycle on the cycle after the last sample, and no later write of the program is issued.
- R7: `done_o` pulses for one cycle on the cycle after the final bit-30-clear poll matches.
- R8: A start pulse that arrives while `busy_o` is high is ignored and does not change the timing or the write sequence of the run in progress.
- R9: `done_o` and `error_o` are never high together, each run ends with exactly one of them, and `busy_o` is low in the cycle of that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse; sampled only while idle |
| busy_o | output | 1 | High from the cycle after an accepted start until the run ends |
| done_o | output | 1 | One-cycle success pulse |
| error_o | output | 1 | One-cycle timeout pulse |
| set_we_o | output | 1 | Strobe: OR `wmask_o` into the control word |
| clr_we_o | output | 1 | Strobe: clear the `wmask_o` bits in the control word |
| wmask_o | output | 32 | One-hot write mask, valid with a strobe |
| rdata_i | input | 32 | Current control word read back from the peripheral |

## Verification
On every cycle, assertions check that the strobes are mutually exclusive and one-hot masked, that they appear only while busy, that the first poll follows a full settle window, that poll counters stay in range, and that done and error are exclusive single-cycle pulses, with an error only after an exhausted, unmatched poll. Only the bench scenarios can show the end-to-end timing against a responding peripheral. This covers the exact write order and write cycles, the acknowledgement wait for various response delays, the success/timeout boundary on the last poll sample, which writes are skipped after a timeout in each phase, and that a start during a run changes nothing.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int WORD_W    = 32;
  localparam int RST_BIT   = 31;   // soft-reset control bit
  localparam int GATE_BIT  = 30;   // clock-gate control bit
  localparam int NUM_STEPS = 5;
  localparam int STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WRITE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_POLL   = 2'd3
  } seq_state_e;

  // One entry of the fixed write/poll program.
  typedef struct packed {
    logic wr_gate;    // 1: write targets the clock-gate bit, 0: soft-reset bit
    logic set_op;     // 1: set strobe, 0: clear strobe
    logic polled;     // 1: settle then poll after the write
    logic poll_gate;  // bit examined while polling
    logic want;       // value that ends the poll loop
  } step_t;

  function automatic step_t step_of(input logic [STEP_W-1:0] idx);
    step_t s;
    case (idx)
      3'd0:    s = '{wr_gate:1'b0, set_op:1'b0, polled:1'b1, poll_gate:1'b0, want:1'b0};
      3'd1:    s = '{wr_gate:1'b1, set_op:1'b0, polled:1'b0, poll_gate:1'b1, want:1'b0};
      3'd2:    s = '{wr_gate:1'b0, set_op:1'b1, polled:1'b1, poll_gate:1'b1, want:1'b1};
      3'd3:    s = '{wr_gate:1'b0, set_op:1'b0, polled:1'b1, poll_gate:1'b0, want:1'b0};
      3'd4:    s = '{wr_gate:1'b1, set_op:1'b0, polled:1'b1, poll_gate:1'b1, want:1'b0};
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] mask_for(input logic gate_sel);
    logic [WORD_W-1:0] m;
    m = '0;
    if (gate_sel) m[GATE_BIT] = 1'b1;
    else          m[RST_BIT]  = 1'b1;
    return m;
  endfunction

  function automatic logic sample_ok(input logic [WORD_W-1:0] word, input step_t s);
    logic b;
    b = s.poll_gate ? word[GATE_BIT] : word[RST_BIT];
    return b == s.want;
  endfunction

endpackage

// File: rtl/rsq_cycle_counter.sv
module rsq_cycle_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)          cnt <= '0;
    else if (inc && !last)   cnt <= cnt + CW'(1);
  end

  assign last = (cnt == TOP);

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !last) |=> (cnt == $past(cnt) + CW'(1)));

endmodule

// File: rtl/rsq_reg_port.sv
module rsq_reg_port
  import rsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        state,
  input  step_t             cur,
  input  logic [WORD_W-1:0] rdata,
  output logic              set_we,
  output logic              clr_we,
  output logic [WORD_W-1:0] wmask,
  output logic              sample_hit
);
  logic wr_slot;

  assign wr_slot    = (state == ST_WRITE);
  assign set_we     = wr_slot &&  cur.set_op;
  assign clr_we     = wr_slot && !cur.set_op;
  assign wmask      = wr_slot ? mask_for(cur.wr_gate) : '0;
  assign sample_hit = sample_ok(rdata, cur);

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({set_we, clr_we}));

  assert_mask_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    (set_we || clr_we) |-> ($countones(wmask) == 1));

  assert_mask_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !(set_we || clr_we) |-> (wmask == '0));

endmodule

// File: rtl/rsq_step_ctrl.sv
module rsq_step_ctrl
  import rsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              settle_last,
  input  logic              poll_last,
  input  logic              sample_hit,
  output seq_state_e        state,
  output logic [STEP_W-1:0] step_idx,
  output step_t             cur,
  output logic              done,
  output logic              err
);
  logic final_step;
  logic poll_pass;
  logic poll_fail;

  assign cur        = step_of(step_idx);
  assign final_step = (step_idx == STEP_W'(NUM_STEPS - 1));
  assign poll_pass  = (state == ST_POLL) &&  sample_hit;
  assign poll_fail  = (state == ST_POLL) && !sample_hit && poll_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step_idx <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_WRITE;
            step_idx <= '0;
          end
        end
        ST_WRITE: begin
          if (cur.polled) state <= ST_SETTLE;
          else            step_idx <= step_idx + STEP_W'(1);
        end
        ST_SETTLE: begin
          if (settle_last) state <= ST_POLL;
        end
        ST_POLL: begin
          if (poll_pass) begin
            if (final_step) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              step_idx <= step_idx + STEP_W'(1);
              state    <= ST_WRITE;
            end
          end else if (poll_fail) begin
            err   <= 1'b1;
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && !done && !err));

  assert_settle_full_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POLL && $past(state) == ST_SETTLE) |-> $past(settle_last));

  assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(state) == ST_POLL && $past(poll_last) && !$past(sample_hit)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  assert_restart_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WRITE && step_idx == '0) |-> ($past(state) == ST_IDLE || $past(state) == ST_WRITE && $past(step_idx) == '0 && 1'b0 || $past(state) == ST_IDLE));

  assert_end_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && err));

  assert_end_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> (state == ST_IDLE));

endmodule

// File: rtl/soft_reset_sequencer.sv
module soft_reset_sequencer
  import rsq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 8,
  parameter int MAX_POLLS     = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              set_we_o,
  output logic              clr_we_o,
  output logic [WORD_W-1:0] wmask_o,
  input  logic [WORD_W-1:0] rdata_i
);
  seq_state_e        state;
  logic [STEP_W-1:0] step_idx;
  step_t             cur;
  logic              settle_last;
  logic              poll_last;
  logic              sample_hit;
  logic              in_settle;
  logic              in_poll;

  assign in_settle = (state == ST_SETTLE);
  assign in_poll   = (state == ST_POLL);
  assign busy_o    = (state != ST_IDLE);

  rsq_step_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .settle_last(settle_last),
    .poll_last  (poll_last),
    .sample_hit (sample_hit),
    .state      (state),
    .step_idx   (step_idx),
    .cur        (cur),
    .done       (done_o),
    .err        (error_o)
  );

  rsq_cycle_counter #(.LIMIT(SETTLE_CYCLES)) u_settle (
    .clk (clk),
    .rst (rst),
    .clr (!in_settle),
    .inc (in_settle),
    .last(settle_last)
  );

  rsq_cycle_counter #(.LIMIT(MAX_POLLS)) u_polls (
    .clk (clk),
    .rst (rst),
    .clr (!in_poll),
    .inc (in_poll),
    .last(poll_last)
  );

  rsq_reg_port u_port (
    .clk       (clk),
    .rst       (rst),
    .state     (state),
    .cur       (cur),
    .rdata     (rdata_i),
    .set_we    (set_we_o),
    .clr_we    (clr_we_o),
    .wmask     (wmask_o),
    .sample_hit(sample_hit)
  );

  assert_strobe_when_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (set_we_o || clr_we_o) |-> busy_o);

  assert_accept_start_R8: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  assert_step_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    step_idx <= STEP_W'(NUM_STEPS - 1));

endmodule

// File: tb/ctl_reg_model.sv
module ctl_reg_model (
  input  logic        clk,
  input  logic        rst,
  input  logic        set_we,
  input  logic        clr_we,
  input  logic [31:0] wmask,
  input  logic [15:0] ack_delay,
  input  logic        no_ack,
  input  logic        stuck_rst,
  input  logic        stuck_gate,
  output logic [31:0] rdata
);
  logic [31:0] word;
  logic [31:0] nxt;
  logic [15:0] hold;
  logic        ack_now;

  assign ack_now = word[31] && !word[30] && !no_ack &&
                   (hold + 16'd1 >= ((ack_delay == 16'd0) ? 16'd1 : ack_delay));

  always_comb begin
    nxt = word;
    if (set_we) nxt = nxt | wmask;
    if (clr_we) nxt = nxt & ~wmask;
    if (ack_now) nxt[30] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= 32'hC000_005A;
      hold <= '0;
    end else begin
      word <= nxt;
      if (word[31] && !word[30]) hold <= hold + 16'd1;
      else                       hold <= '0;
    end
  end

  assign rdata = {stuck_rst | word[31], stuck_gate | word[30], word[29:0]};
endmodule

// File: tb/soft_reset_sequencer_test.sv
module soft_reset_sequencer_test;
  localparam int S = 6;
  localparam int M = 40;
  localparam int RUN_LIMIT = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        busy, done, err, set_we, clr_we;
  logic [31:0] wmask, rdata;
  logic [15:0] ack_delay = 16'd1;
  logic        no_ack = 1'b0, stuck_rst = 1'b0, stuck_gate = 1'b0;

  int checks = 0;
  int errors = 0;

  int          wr_n, n_done, n_err, lat, kind;
  bit          busy_bad;
  logic [33:0] wr_val [16];
  int          wr_at  [16];

  soft_reset_sequencer #(.SETTLE_CYCLES(S), .MAX_POLLS(M)) uut (
    .clk(clk), .rst(rst), .start_i(start), .busy_o(busy), .done_o(done),
    .error_o(err), .set_we_o(set_we), .clr_we_o(clr_we), .wmask_o(wmask),
    .rdata_i(rdata)
  );

  ctl_reg_model u_model (
    .clk(clk), .rst(rst), .set_we(set_we), .clr_we(clr_we), .wmask(wmask),
    .ack_delay(ack_delay), .no_ack(no_ack), .stuck_rst(stuck_rst),
    .stuck_gate(stuck_gate), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected timing, counted in cycles after the start was sampled.
  function automatic int p3_start();            return 5 + 2*S; endfunction
  function automatic int ack_cycle(int d);      return 5 + S + d; endfunction
  function automatic int p3_match(int d);
    int a = ack_cycle(d);
    return (a > p3_start()) ? a : p3_start();
  endfunction
  function automatic int done_cycle(int d);     return p3_match(d) + 5 + 2*S; endfunction

  // Expected write i as {set, clr, mask}.
  function automatic logic [33:0] exp_wr(int i);
    logic [31:0] m31 = 32'h8000_0000;
    logic [31:0] m30 = 32'h4000_0000;
    case (i)
      0: return {2'b01, m31};
      1: return {2'b01, m30};
      2: return {2'b10, m31};
      3: return {2'b01, m31};
      default: return {2'b01, m30};
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    start = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_seq(input int d, input bit a_na, input bit a_sr, input bit a_sg, input int poke);
    ack_delay = 16'(d);
    no_ack = a_na; stuck_rst = a_sr; stuck_gate = a_sg;
    do_reset();
    wr_n = 0; n_done = 0; n_err = 0; lat = -1; kind = 0; busy_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= RUN_LIMIT; n++) begin
      if (set_we || clr_we) begin
        if (wr_n < 16) begin
          wr_val[wr_n] = {set_we, clr_we, wmask};
          wr_at[wr_n]  = n;
        end
        wr_n++;
      end
      if (done) begin
        n_done++;
        if (busy) busy_bad = 1;
        if (lat < 0) begin lat = n; kind = 1; end
      end
      if (err) begin
        n_err++;
        if (busy) busy_bad = 1;
        if (lat < 0) begin lat = n; kind = 2; end
      end
      if (lat >= 0 && n >= lat + 6) break;
      start = (n == poke);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic check_success(input int d, input string tag);
    chk(kind == 1, {"R7 ", tag, " done"}, kind, 1);
    chk(lat == done_cycle(d), {"R3 ", tag, " latency"}, lat, done_cycle(d));
    chk(wr_n == 5, {"R2 ", tag, " write count"}, wr_n, 5);
    for (int i = 0; i < 5 && i < wr_n; i++)
      chk(wr_val[i] == exp_wr(i), {"R2 ", tag, " write order"}, wr_val[i], exp_wr(i));
    if (wr_n >= 5) begin
      chk(wr_at[0] == 1, {"R3 ", tag, " first write"}, wr_at[0], 1);
      chk(wr_at[1] == 3 + S, {"R3 ", tag, " settle before step 2"}, wr_at[1], 3 + S);
      chk(wr_at[2] == wr_at[1] + 1, {"R3 ", tag, " no settle after gate clear"}, wr_at[2], wr_at[1] + 1);
      chk(wr_at[3] == p3_match(d) + 1, {"R4 ", tag, " ack wait"}, wr_at[3], p3_match(d) + 1);
      chk(wr_at[4] == p3_match(d) + 3 + S, {"R3 ", tag, " last write"}, wr_at[4], p3_match(d) + 3 + S);
    end
    chk(n_done + n_err == 1 && !busy_bad, {"R9 ", tag, " single end pulse"}, n_done + n_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd913);

    // R1: reset state
    do_reset();
    rst = 1'b1;
    @(negedge clk);
    chk(!busy && !set_we && !clr_we && !done && !err, "R1 reset outputs", {busy, set_we, clr_we, done, err}, 0);
    rst = 1'b0;

    // R4: acknowledgement arrives before polling starts
    run_seq(1, 0, 0, 0, 0);
    check_success(1, "early ack");

    // R4: slow acknowledgement
    run_seq(S + 15, 0, 0, 0, 0);
    check_success(S + 15, "slow ack");

    // R5: match on the last allowed sample
    run_seq(S + M - 1, 0, 0, 0, 0);
    check_success(S + M - 1, "last sample");

    // R5 R6: one cycle too late -> timeout in the acknowledgement phase
    run_seq(S + M, 0, 0, 0, 0);
    chk(kind == 2, "R5 one past limit", kind, 2);
    chk(lat == p3_start() + M, "R6 ack timeout cycle", lat, p3_start() + M);
    chk(wr_n == 3, "R6 ack timeout skips writes", wr_n, 3);

    // R6: peripheral never acknowledges
    run_seq(1, 1, 0, 0, 0);
    chk(kind == 2 && lat == p3_start() + M, "R6 no ack", lat, p3_start() + M);
    chk(n_done == 0 && n_err == 1 && !busy_bad, "R9 no ack single error", n_err, 1);

    // R6: soft reset never reads back clear -> first phase times out
    run_seq(1, 0, 1, 0, 0);
    chk(kind == 2 && lat == 2 + S + M, "R6 first phase timeout", lat, 2 + S + M);
    chk(wr_n == 1, "R6 first phase skips writes", wr_n, 1);
    chk(rdata[30] == 1'b1, "R6 gate bit untouched", rdata[30], 1);

    // R6: gate bit stuck high -> last phase times out
    run_seq(3, 0, 0, 1, 0);
    chk(kind == 2 && lat == p3_start() + 4 + 2*S + M, "R6 last phase timeout", lat, p3_start() + 4 + 2*S + M);
    chk(wr_n == 5, "R6 last phase write count", wr_n, 5);

    // R8: start during a run
    run_seq(10, 0, 0, 0, 4);
    check_success(10, "R8 start while busy");
    run_seq(10, 0, 0, 0, p3_start() + 2);
    check_success(10, "R8 start while polling");
    chk(n_done == 1, "R8 one done only", n_done, 1);

    // R1: reset in the middle of a run
    ack_delay = 16'd20; no_ack = 0; stuck_rst = 0; stuck_gate = 0;
    do_reset();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (S + 3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !set_we && !clr_we && !done && !err, "R1 mid-run reset", {busy, set_we, clr_we, done, err}, 0);
    begin
      int quiet = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (set_we || clr_we || done || err || busy) quiet++;
      end
      chk(quiet == 0, "R1 silent after reset", quiet, 0);
    end

    // Random mix with a fixed seed
    for (int i = 0; i < 14; i++) begin
      int d;
      int pk;
      d  = 1 + int'($urandom % (S + M + 10));
      pk = (($urandom % 3) == 0) ? 2 + int'($urandom % 30) : 0;
      run_seq(d, 0, 0, 0, pk);
      if (d <= S + M - 1) begin
        check_success(d, "random");
      end else begin
        chk(kind == 2 && lat == p3_start() + M, "R6 random timeout", lat, p3_start() + M);
        chk(wr_n == 3, "R6 random timeout writes", wr_n, 3);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule